// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock waveform for an I2C master from a fast module clock. A prescaler first divides the input clock into ticks. Two phase timers then count the low and the high half of the serial clock in those ticks. Each half is lengthened by a fixed number of ticks that the block adds on its own. That offset is 7 when the prescale setting is zero, 6 when it is one, and 5 for any larger setting. The full serial period is therefore `(low + d) + (high + d)` ticks, and each tick lasts `prescale + 1` input cycles.

The output is a request to pull the clock line low, with `1` meaning "drive low" and `0` meaning "release". Two one-cycle strobes mark the first cycle of each low phase and each high phase. Software is expected to hold the enable low while it writes the three settings. A high setting of zero is illegal, and in that case the block generates no clock. Settings that change during a running period are taken only when the next low phase starts.

Top module: `scl_clkgen`

## Requirements
- R1: Each prescaled tick lasts `psc_val + 1` input clock cycles, so every phase length in input cycles is a multiple of `psc_val + 1`.
- R2: The hidden offset d added to each phase is 7 when the latched prescale value is 0, 6 when it is 1, and 5 when it is 2 or more.
- R3: The low phase (`scl_drive_low` = 1) lasts exactly `(low_val + d) * (psc_val + 1)` input clock cycles.
- R4: The high phase (`scl_drive_low` = 0 between two low phases) lasts exactly `(high_val + d) * (psc_val + 1)` input clock cycles.
- R5: After `enable` is sampled high at a clock edge while idle with a nonzero `high_val`, the low phase starts in the following cycle, with `scl_drive_low` = 1 and `low_start` = 1. The high phase comes only after it.
- R6: `low_start` is high for exactly the first cycle of each low phase, and `high_start` is high for exactly the first cycle of each high phase. The two are never high together.
- R7: When `high_val` is 0 at the point where a low phase would start, no low phase starts. The clock line stays released and neither strobe fires.
- R8: Values on `psc_val`, `low_val` and `high_val` are latched only when a low phase starts. A change during a running period does not alter that period.
- R9: While `rst_n` is low, or one cycle after `enable` is sampled low, `scl_drive_low` and both strobes are 0. A later enable restarts with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 runs the divider; 0 holds it idle with counters cleared |
| psc_val | input | CNT_W | Prescale setting; tick = psc_val + 1 input cycles |
| low_val | input | CNT_W | Low-phase setting in ticks, before the offset |
| high_val | input | CNT_W | High-phase setting in ticks, before the offset; 0 stops the clock |
| scl_drive_low | output | 1 | 1 requests the clock line be pulled low |
| low_start | output | 1 | One-cycle strobe in the first cycle of a low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of a high phase |

## Verification
The embedded properties check, on every cycle, the ordering rules. A low phase opens only with its strobe, a high strobe follows a low cycle, and the two strobes are never high together. They also check that disabling silences the outputs and that the tick and phase counters stay below their limits. Phase lengths in cycles, the offset mapping and the moment new settings take effect can only be shown by the bench's scenarios. The bench sweeps prescale, low and high settings, changes settings during a period, and stops the clock with a zero high setting, both from idle and while running.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

   localparam int unsigned OFS_W    = 3;
   localparam int unsigned OFS_PSC0 = 7;
   localparam int unsigned OFS_PSC1 = 6;
   localparam int unsigned OFS_PSCN = 5;

   // Extra ticks added to every phase, selected by the prescale value.
   function automatic logic [OFS_W-1:0] phase_offset(input logic psc_zero,
                                                     input logic psc_one);
      if (psc_zero)
         return OFS_W'(OFS_PSC0);
      else if (psc_one)
         return OFS_W'(OFS_PSC1);
      else
         return OFS_W'(OFS_PSCN);
   endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt_q <= '0;
      else if (cnt_q == limit)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R1: the tick counter never passes the latched prescale limit
   a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int unsigned LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   output logic             last
);

   logic [LEN_W-1:0] cnt_q;

   assign last = tick && (cnt_q == len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt_q <= '0;
      else if (last)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // R3: the tick count inside a phase stays below the phase length
   a_r3_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < len));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
   import scl_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] psc_val,
   input  logic [CNT_W-1:0] low_val,
   input  logic [CNT_W-1:0] high_val,
   output logic             scl_drive_low,
   output logic             low_start,
   output logic             high_start
);

   localparam int unsigned LEN_W = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("scl_clkgen: CNT_W must be at least 2");
      end
   endgenerate

   scl_phase_e       state_q, state_d;
   logic             load;
   logic             run;
   logic             tick;
   logic             last;
   logic [CNT_W-1:0] psc_l, low_l, high_l;
   logic [OFS_W-1:0] ofs;
   logic [LEN_W-1:0] cur_len;
   logic             low_start_q, high_start_q;

   assign run = enable && (state_q != PH_IDLE);
   assign ofs = phase_offset(psc_l == '0, psc_l == CNT_W'(1));
   assign cur_len = {1'b0, (state_q == PH_HIGH) ? high_l : low_l} + LEN_W'(ofs);

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      if (!enable) begin
         state_d = PH_IDLE;
      end else begin
         case (state_q)
            PH_IDLE: begin
               if (high_val != '0) begin
                  state_d = PH_LOW;
                  load    = 1'b1;
               end
            end
            PH_LOW: begin
               if (last)
                  state_d = PH_HIGH;
            end
            PH_HIGH: begin
               if (last) begin
                  if (high_val != '0) begin
                     state_d = PH_LOW;
                     load    = 1'b1;
                  end else begin
                     state_d = PH_IDLE;
                  end
               end
            end
            default: state_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= PH_IDLE;
         psc_l        <= '0;
         low_l        <= '0;
         high_l       <= '0;
         low_start_q  <= 1'b0;
         high_start_q <= 1'b0;
      end else begin
         state_q      <= state_d;
         low_start_q  <= load;
         high_start_q <= (state_q == PH_LOW) && (state_d == PH_HIGH);
         if (load) begin
            psc_l  <= psc_val;
            low_l  <= low_val;
            high_l <= high_val;
         end
      end
   end

   scl_prescale #(.CNT_W(CNT_W)) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .limit (psc_l),
      .tick  (tick)
   );

   scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .len   (cur_len),
      .last  (last)
   );

   assign scl_drive_low = (state_q == PH_LOW);
   assign low_start     = low_start_q;
   assign high_start    = high_start_q;

   // R6: strobes are exclusive
   a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(low_start && high_start));
   // R6: a high phase follows a low cycle
   a_r6_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      high_start |-> $past(scl_drive_low));
   // R5: a low phase never opens without its strobe
   a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> low_start);
   // R5: enabling from idle with a legal high setting starts a low phase
   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(enable) && (high_val != '0)) |=> low_start);
   // R7: a started low phase always carries a nonzero high setting
   a_r7_nonzero_high: assert property (@(posedge clk) disable iff (!rst_n)
      low_start |-> (high_l != '0));
   // R9: disabling silences every output one cycle later
   a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !low_start && !high_start));

endmodule

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic [W-1:0] psc_val = '0;
   logic [W-1:0] low_val = '0;
   logic [W-1:0] high_val = '0;
   logic         scl_drive_low, low_start, high_start;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   scl_clkgen #(.CNT_W(W)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .psc_val       (psc_val),
      .low_val       (low_val),
      .high_val      (high_val),
      .scl_drive_low (scl_drive_low),
      .low_start     (low_start),
      .high_start    (high_start)
   );

   function automatic int exp_ofs(int p);
      if (p == 0) return 7;
      if (p == 1) return 6;
      return 5;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_low_start();
      for (int i = 0; i < 4000; i++) begin
         if (low_start) return;
         @(negedge clk);
      end
   endtask

   task automatic measure(output int nl, output int nh, output int hs);
      nl = 0;
      nh = 0;
      while (scl_drive_low && nl < 5000) begin
         nl++;
         @(negedge clk);
      end
      hs = int'(high_start);
      while (!scl_drive_low && nh < 5000) begin
         nh++;
         @(negedge clk);
      end
   endtask

   task automatic count_activity(int n, output int act);
      act = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (scl_drive_low || low_start || high_start) act++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R5 actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int nl, nh, hs, act;
      int lows[3];
      int highs[2];
      lows  = '{0, 1, 4};
      highs = '{1, 3};

      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 reset drive_low", int'(scl_drive_low), 0);
      chk("R9 reset strobes", int'(low_start | high_start), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6: sweep of settings
      for (int p = 0; p < 4; p++) begin
         for (int li = 0; li < 3; li++) begin
            for (int hi = 0; hi < 2; hi++) begin
               enable   = 1'b0;
               psc_val  = W'(p);
               low_val  = W'(lows[li]);
               high_val = W'(highs[hi]);
               @(negedge clk);
               enable = 1'b1;
               @(negedge clk);
               chk("R5 low_start after enable", int'(low_start), 1);
               chk("R5 drive low first", int'(scl_drive_low), 1);
               measure(nl, nh, hs);
               chk("R1 R2 R3 low length", nl, (lows[li] + exp_ofs(p)) * (p + 1));
               chk("R1 R2 R4 high length", nh, (highs[hi] + exp_ofs(p)) * (p + 1));
               chk("R6 high_start at high entry", hs, 1);
               chk("R6 low_start at next low", int'(low_start), 1);
            end
         end
      end

      // R8: settings change mid-period
      enable   = 1'b0;
      psc_val  = 16'd1;
      low_val  = 16'd2;
      high_val = 16'd1;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      wait_low_start();
      psc_val = 16'd0;
      low_val = 16'd5;
      measure(nl, nh, hs);
      chk("R8 running low kept", nl, 16);
      chk("R8 running high kept", nh, 14);
      measure(nl, nh, hs);
      chk("R8 new low applied", nl, 12);
      chk("R8 new high applied", nh, 8);

      // R7: zero high setting stops the clock after the running period
      high_val = 16'd0;
      repeat (40) @(negedge clk);
      count_activity(300, act);
      chk("R7 stop while running", act, 0);

      // R7: zero high setting from idle
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      count_activity(200, act);
      chk("R7 no clock from idle", act, 0);

      // R9: disable mid-phase, then restart with full phases
      enable   = 1'b0;
      psc_val  = 16'd2;
      low_val  = 16'd3;
      high_val = 16'd2;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      wait_low_start();
      repeat (3) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R9 released after disable", int'(scl_drive_low), 0);
      count_activity(50, act);
      chk("R9 silent while disabled", act, 0);
      enable = 1'b1;
      @(negedge clk);
      chk("R9 restart low_start", int'(low_start), 1);
      measure(nl, nh, hs);
      chk("R9 restart full low", nl, 24);
      chk("R9 restart full high", nh, 21);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule